// File: doc/BRIEF.md
# Single-Phase Buck Switch Controller

This block sequences the two power switches of one synchronous buck phase from a digital clock domain. A charge cycle turns the high-side switch on. An over-current event ends that charge. The controller then hands conduction to the low-side switch, and it decides whether the low-side interval ends in idle or in a new charge.

Each gate request is released, and the other gate's acknowledge is seen low, before the opposite request is raised. Both switches have a programmable minimum conduction time, counted from the first clock edge at which their acknowledge is sampled high. Comparator inputs are assumed to be synchronised already. A one-cycle pulse that arrives while the controller waits for a handshake is held until the controller can act on it. A programmable timeout flags a handshake that never completes. A higher-level scheduler may also start a charge directly.

Top module: `buck_phase_ctrl`

## Requirements
- R1: After reset both gate requests and `ack_fault` are low, and they stay low while no start source is active.
- R2: In idle, a high `uv_det` (level or single-cycle pulse) or a high `sched_start` raises `hs_on_req` on the next clock edge, but only at an edge where `ls_on_ack` is sampled low. A start seen while `ls_on_ack` is high is held and acted on once it falls.
- R3: `hs_on_req` and `ls_on_req` are never high together. `hs_on_req` rises only after an edge that sampled `ls_on_ack` low, and `ls_on_req` rises only after an edge that sampled `hs_on_ack` low.
- R4: `hs_on_req` stays high until at least max(`hs_min_cyc`,1) edges after the first edge that samples `hs_on_ack` high. With an over-current already seen, it falls exactly then. With acknowledge latency A cycles, the high time is A+1+max(`hs_min_cyc`,1) cycles.
- R5: An over-current ends the charge. `hs_on_req` falls, and `ls_on_req` rises on the edge after `hs_on_ack` is first sampled low, so the gap is A+1 cycles.
- R6: `ls_on_req` obeys the same rule with `ls_min_cyc`. Its high time is A+1+max(`ls_min_cyc`,1) cycles when its ending event is already seen.
- R7: Zero-crossing seen during charge or low-side conduction ends the low-side interval at its minimum time. Both requests then stay low until a new start, and zero-crossing wins over a pending under-voltage.
- R8: Under-voltage seen during the low-side interval with no zero-crossing makes the controller drop `ls_on_req`. It then raises `hs_on_req` again A+1 cycles later, with no new start.
- R9: Single-cycle `oc_det`, `zc_det` or `uv_det` pulses are held until used. Over-current and zero-crossing seen before a charge starts are discarded when the charge starts.
- R10: If a wait for an acknowledge lasts `ack_limit`+1 cycles, `ack_fault` rises and stays high until reset. Shorter waits never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_start | input | 1 | Start request from a scheduler, used in idle only |
| uv_det | input | 1 | Output voltage below target |
| oc_det | input | 1 | Inductor current at its upper limit |
| zc_det | input | 1 | Inductor current reached zero |
| hs_on_ack | input | 1 | High-side switch reports conducting |
| ls_on_ack | input | 1 | Low-side switch reports conducting |
| hs_min_cyc | input | CNT_W | Minimum high-side on cycles (0 acts as 1) |
| ls_min_cyc | input | CNT_W | Minimum low-side on cycles (0 acts as 1) |
| ack_limit | input | TMO_W | Handshake timeout in cycles |
| hs_on_req | output | 1 | High-side gate request |
| ls_on_req | output | 1 | Low-side gate request |
| ack_fault | output | 1 | Sticky handshake timeout flag |

## Verification
The bench sweeps both minimum times from 0 to 3 and the acknowledge latency from one to three cycles. It runs each combination in both the early zero-crossing and the recharge ordering, and measures every pulse and gap to the cycle. A design that mishandled zero minimum, counted from the request rather than the acknowledge, or dropped a pulse seen during a handshake would be off by cycles or would hang in conduction. A switch overlap check runs on every cycle. Directed cases cover a start held off by a stuck low-side acknowledge, a stale over-current that must not cut a new charge short, and a timeout that must fire on time and stay set.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  localparam int ARG_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_P_ACQ = 3'd1,
    ST_P_ON  = 3'd2,
    ST_P_REL = 3'd3,
    ST_N_ACQ = 3'd4,
    ST_N_ON  = 3'd5,
    ST_N_REL = 3'd6
  } bpc_state_e;

  // effective minimum: a zero setting behaves as one cycle
  function automatic logic [ARG_W-1:0] eff_min(input logic [ARG_W-1:0] lim);
    return (lim == '0) ? ARG_W'(1) : lim;
  endfunction

  function automatic logic min_met(input logic [ARG_W-1:0] cnt,
                                   input logic [ARG_W-1:0] lim);
    return cnt >= eff_min(lim);
  endfunction

  function automatic logic is_wait(input bpc_state_e s);
    return (s == ST_P_ACQ) || (s == ST_P_REL) ||
           (s == ST_N_ACQ) || (s == ST_N_REL);
  endfunction

endpackage

// File: rtl/bpc_evt_latch.sv
module bpc_evt_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] clr,
  output logic [N-1:0] seen
);

  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rst_n)      pend_q[i] <= 1'b0;
      else if (clr[i]) pend_q[i] <= 1'b0;
      else if (raw[i]) pend_q[i] <= 1'b1;
    end
    assign seen[i] = pend_q[i] | raw[i];

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !clr[i]) |=> pend_q[i]); // R9
  end

endmodule

// File: rtl/bpc_min_timer.sv
module bpc_min_timer
  import bpc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         run,
  input  logic [W-1:0] lim,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (start)                 cnt_q <= W'(1);
    else if (run && cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign done = min_met(ARG_W'(cnt_q), ARG_W'(lim));

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && $past(run) && cnt_q != '0) |=> cnt_q != '0); // R4

endmodule

// File: rtl/bpc_ack_watch.sv
module bpc_ack_watch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         waiting,
  input  logic         done,
  input  logic [W-1:0] limit,
  output logic         fault
);

  logic [W-1:0] wcnt_q;
  logic         fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      fault_q <= 1'b0;
    end else if (!waiting || done) begin
      wcnt_q <= '0;
    end else if (wcnt_q == limit) begin
      fault_q <= 1'b1;
    end else begin
      wcnt_q <= wcnt_q + 1'b1;
    end
  end

  assign fault = fault_q;

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q); // R10
  AST_FAULT_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(waiting)); // R10

endmodule

// File: rtl/buck_phase_ctrl.sv
module buck_phase_ctrl
  import bpc_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sched_start,
  input  logic             uv_det,
  input  logic             oc_det,
  input  logic             zc_det,
  input  logic             hs_on_ack,
  input  logic             ls_on_ack,
  input  logic [CNT_W-1:0] hs_min_cyc,
  input  logic [CNT_W-1:0] ls_min_cyc,
  input  logic [TMO_W-1:0] ack_limit,
  output logic             hs_on_req,
  output logic             ls_on_req,
  output logic             ack_fault
);

  localparam int EV_N  = 3;
  localparam int EV_UV = 0;
  localparam int EV_OC = 1;
  localparam int EV_ZC = 2;

  bpc_state_e st_q, st_d;
  logic       rech_q, rech_d;

  logic [EV_N-1:0] ev_raw, ev_clr, ev_seen;
  logic uv_seen, oc_seen, zc_seen;
  logic p_done, n_done;
  logic enter_pacq, enter_nacq, leave_pon, leave_non;
  logic start_ok;

  // event capture
  assign ev_raw[EV_UV] = uv_det;
  assign ev_raw[EV_OC] = oc_det;
  assign ev_raw[EV_ZC] = zc_det;

  assign uv_seen = ev_seen[EV_UV];
  assign oc_seen = ev_seen[EV_OC];
  assign zc_seen = ev_seen[EV_ZC];

  assign enter_pacq = (st_d == ST_P_ACQ) && (st_q != ST_P_ACQ);
  assign enter_nacq = (st_d == ST_N_ACQ) && (st_q != ST_N_ACQ);
  assign leave_pon  = (st_q == ST_P_ON)  && (st_d != ST_P_ON);
  assign leave_non  = (st_q == ST_N_ON)  && (st_d != ST_N_ON);

  assign ev_clr[EV_UV] = enter_pacq || enter_nacq || (leave_non && rech_d);
  assign ev_clr[EV_OC] = enter_pacq || leave_pon;
  assign ev_clr[EV_ZC] = enter_pacq || leave_non;

  bpc_evt_latch #(.N(EV_N)) i_evt (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (ev_raw),
    .clr  (ev_clr),
    .seen (ev_seen)
  );

  // minimum conduction timers
  bpc_min_timer #(.W(CNT_W)) i_pmin (
    .clk  (clk),
    .rst_n(rst_n),
    .start(st_q == ST_P_ACQ && st_d == ST_P_ON),
    .run  (st_q == ST_P_ON),
    .lim  (hs_min_cyc),
    .done (p_done)
  );

  bpc_min_timer #(.W(CNT_W)) i_nmin (
    .clk  (clk),
    .rst_n(rst_n),
    .start(st_q == ST_N_ACQ && st_d == ST_N_ON),
    .run  (st_q == ST_N_ON),
    .lim  (ls_min_cyc),
    .done (n_done)
  );

  // handshake timeout
  bpc_ack_watch #(.W(TMO_W)) i_watch (
    .clk    (clk),
    .rst_n  (rst_n),
    .waiting(is_wait(st_q)),
    .done   (st_d != st_q),
    .limit  (ack_limit),
    .fault  (ack_fault)
  );

  // sequencing
  assign start_ok = (uv_seen || sched_start) && !ls_on_ack;

  always_comb begin
    st_d   = st_q;
    rech_d = rech_q;
    unique case (st_q)
      ST_IDLE:  if (start_ok) st_d = ST_P_ACQ;
      ST_P_ACQ: if (hs_on_ack) st_d = ST_P_ON;
      ST_P_ON:  if (p_done && oc_seen) st_d = ST_P_REL;
      ST_P_REL: if (!hs_on_ack) st_d = ST_N_ACQ;
      ST_N_ACQ: if (ls_on_ack) st_d = ST_N_ON;
      ST_N_ON: begin
        if (n_done && zc_seen) begin
          st_d   = ST_N_REL;
          rech_d = 1'b0;
        end else if (n_done && uv_seen) begin
          st_d   = ST_N_REL;
          rech_d = 1'b1;
        end
      end
      ST_N_REL: if (!ls_on_ack) st_d = rech_q ? ST_P_ACQ : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rech_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rech_q <= rech_d;
    end
  end

  assign hs_on_req = (st_q == ST_P_ACQ) || (st_q == ST_P_ON);
  assign ls_on_req = (st_q == ST_N_ACQ) || (st_q == ST_N_ON);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on_req && ls_on_req)); // R3
  AST_HS_AFTER_LS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on_req) |-> !$past(ls_on_ack)); // R3
  AST_LS_AFTER_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on_req) |-> !$past(hs_on_ack)); // R5
  AST_HS_MIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_on_req) |-> $past(p_done)); // R4
  AST_LS_MIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ls_on_req) |-> $past(n_done)); // R6
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!hs_on_req && !ls_on_req)); // R1

endmodule

// File: tb/test_buck_phase_ctrl.sv
`timescale 1ns/1ps
module test_buck_phase_ctrl;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        sched_start = 1'b0, uv_det = 1'b0, oc_det = 1'b0, zc_det = 1'b0;
  logic        hs_on_ack, ls_on_ack;
  logic [7:0]  hs_min_cyc = 8'd1, ls_min_cyc = 8'd1;
  logic [15:0] ack_limit = 16'd20;
  logic        hs_on_req, ls_on_req, ack_fault;

  int total = 0, bad = 0, ovl = 0;
  int lat = 0;            // acknowledge latency is lat+1 cycles
  bit hs_stuck = 1'b0, ls_force = 1'b0;
  logic [2:0] hs_sr, ls_sr;

  buck_phase_ctrl i_buck_phase_ctrl (
    .clk(clk), .rst_n(rst_n), .sched_start(sched_start),
    .uv_det(uv_det), .oc_det(oc_det), .zc_det(zc_det),
    .hs_on_ack(hs_on_ack), .ls_on_ack(ls_on_ack),
    .hs_min_cyc(hs_min_cyc), .ls_min_cyc(ls_min_cyc), .ack_limit(ack_limit),
    .hs_on_req(hs_on_req), .ls_on_req(ls_on_req), .ack_fault(ack_fault)
  );

  // switch model: acknowledge follows request after lat+1 cycles
  always @(posedge clk) begin
    if (!rst_n) begin
      hs_sr <= '0;
      ls_sr <= '0;
    end else begin
      hs_sr <= {hs_sr[1:0], hs_on_req};
      ls_sr <= {ls_sr[1:0], ls_on_req};
    end
  end
  always_comb begin
    hs_on_ack = hs_stuck ? 1'b0 : hs_sr[lat];
    ls_on_ack = ls_force ? 1'b1 : ls_sr[lat];
  end

  always @(negedge clk)
    if (rst_n && ((hs_on_req && ls_on_req) || (hs_on_req && ls_on_ack) ||
                  (ls_on_req && hs_on_ack)))
      ovl++;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {sched_start, uv_det, oc_det, zc_det} = '0;
    hs_stuck = 1'b0;
    ls_force = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  function automatic bit sig(input int which);
    case (which)
      0:       return hs_on_req;
      1:       return ls_on_req;
      default: return !hs_on_req && !ls_on_req;
    endcase
  endfunction

  // counts consecutive negedge samples where the chosen signal is high
  task automatic run_len(input int which, input int cap, output int n);
    n = 0;
    while (sig(which) && n < cap) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic int effm(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    // R1: reset state and idle
    do_reset();
    tick(5);
    check("R1 hs", hs_on_req, 0);
    check("R1 ls", ls_on_req, 0);
    check("R1 fault", ack_fault, 0);

    // sweep: minimum times, latency, ordering
    for (int p = 0; p < 4; p++) begin
      for (int q = 0; q < 4; q++) begin
        for (int d = 0; d < 3; d++) begin
          for (int mode = 0; mode < 2; mode++) begin
            lat = d;
            hs_min_cyc = 8'(p);
            ls_min_cyc = 8'(q);
            do_reset();
            oc_det = 1'b1;
            zc_det = (mode == 0);
            uv_det = 1'b1;
            tick(1);
            check("R2 start", hs_on_req, 1);
            if (mode == 0) uv_det = 1'b0;
            run_len(0, 100, n);
            check("R4 hs width", n, d + 2 + effm(p));
            run_len(2, 100, n);
            check("R5 gap", n, d + 2);
            run_len(1, 100, n);
            check("R6 ls width", n, d + 2 + effm(q));
            if (mode == 0) begin
              run_len(2, 30, n);
              check("R7 stays idle", n, 30);
            end else begin
              run_len(2, 100, n);
              check("R8 recharge gap", n, d + 2);
              run_len(0, 100, n);
              check("R8 second hs width", n, d + 2 + effm(p));
            end
            check("R10 no fault", ack_fault, 0);
          end
        end
      end
    end

    // R2: scheduler start
    lat = 0;
    hs_min_cyc = 8'd2;
    ls_min_cyc = 8'd2;
    do_reset();
    sched_start = 1'b1;
    tick(1);
    sched_start = 1'b0;
    check("R2 sched start", hs_on_req, 1);

    // R2: start held off by high low-side acknowledge, then serviced
    do_reset();
    ls_force = 1'b1;
    uv_det = 1'b1;
    tick(1);
    uv_det = 1'b0;
    tick(10);
    check("R2 held off", hs_on_req, 0);
    ls_force = 1'b0;
    tick(1);
    check("R2 held start", hs_on_req, 1);

    // R9: pulses during handshake waits
    lat = 2;
    do_reset();
    uv_det = 1'b1;
    tick(1);
    uv_det = 1'b0;
    oc_det = 1'b1;
    tick(1);
    oc_det = 1'b0;
    run_len(0, 100, n);
    check("R9 oc pulse width", n + 1, 4 + 2);
    run_len(2, 100, n);
    check("R9 gap", n, 4);
    zc_det = 1'b1;
    tick(1);
    zc_det = 1'b0;
    run_len(1, 100, n);
    check("R9 zc pulse width", n + 1, 4 + 2);
    run_len(2, 20, n);
    check("R7 idle after pulse", n, 20);

    // R9: stale over-current before a charge is discarded
    lat = 0;
    do_reset();
    oc_det = 1'b1;
    tick(1);
    oc_det = 1'b0;
    tick(2);
    uv_det = 1'b1;
    tick(1);
    uv_det = 1'b0;
    tick(20);
    check("R9 stale oc ignored", hs_on_req, 1);

    // R10: handshake timeout and stickiness
    ack_limit = 16'd5;
    do_reset();
    hs_stuck = 1'b1;
    uv_det = 1'b1;
    tick(1);
    uv_det = 1'b0;
    tick(5);
    check("R10 not yet", ack_fault, 0);
    tick(2);
    check("R10 fault", ack_fault, 1);
    hs_stuck = 1'b0;
    tick(20);
    check("R10 sticky", ack_fault, 1);

    check("R3 overlap count", ovl, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule